// File: doc/BRIEF.md
# Pipelined Control Decoder

This block sits in the decode stage of a five-stage in-order processor pipeline. It turns the 6-bit opcode of the instruction being decoded into a nine-bit control word. It then carries that word down the pipeline so that each stage sees the controls that belong to the instruction it is currently working on. The control word is split into three bundles: execute, memory and writeback. Each pipeline register keeps only the bundles that later stages still consume. The decode-to-execute register holds all three bundles, the execute-to-memory register holds memory and writeback, and the memory-to-writeback register holds writeback alone.

Two requests from the hazard logic act on the pipeline. A bubble request makes the entry that moves into the execute stage a no-op, which is how a load-use stall is inserted. A flush request squashes the instructions in both decode and execute, which discards the wrong-path instructions when a branch resolves as taken. Datapath multiplexers, the ALU function decode and the register file lie outside this block.

Top module: `pipeCtrlDecoder`

## Requirements
- R1: Opcode 0x00 (register-format ALU) decodes to regDst=1, aluOp=2'b10, aluSrc=0, branch=0, memRead=0, memWrite=0, regWrite=1, memToReg=0.
- R2: Opcode 0x23 (load word) decodes to regDst=0, aluOp=2'b00, aluSrc=1, branch=0, memRead=1, memWrite=0, regWrite=1, memToReg=1.
- R3: Opcode 0x2B (store word) decodes to aluOp=2'b00, aluSrc=1, memWrite=1, and every other control is 0, including the don't-care regDst and memToReg.
- R4: Opcode 0x04 (branch-if-equal) decodes to aluOp=2'b01, branch=1, and every other control is 0, including the don't-care regDst and memToReg.
- R5: Any opcode other than the four above decodes to all nine controls at 0.
- R6: An opcode sampled at clock edge k appears on the execute bundle after edge k, on the memory bundle after edge k+1 and on the writeback bundle after edge k+2, so each bundle tracks its own instruction.
- R7: A bubble request at edge k loads all zeros into the decode-to-execute register, while the older instructions in the memory and writeback stages advance unchanged.
- R8: A flush request at edge k loads all zeros into both the decode-to-execute and execute-to-memory registers, while the writeback register still takes the memory stage's writeback bundle. A flush together with a bubble acts as a flush.
- R9: A synchronous reset clears every pipeline control register, so all outputs read 0 after the edge.
- R10: The memory bundle never asserts memRead and memWrite together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode of the instruction in decode |
| bubbleReq | input | 1 | Insert a no-op into the execute stage |
| flushReq | input | 1 | Squash the decode and execute stage instructions |
| exRegDst | output | 1 | Execute: destination register select |
| exAluOp | output | 2 | Execute: ALU operation class |
| exAluSrc | output | 1 | Execute: ALU second operand select |
| memBranch | output | 1 | Memory: branch instruction |
| memRead | output | 1 | Memory: data memory read |
| memWrite | output | 1 | Memory: data memory write |
| wbRegWrite | output | 1 | Writeback: register file write enable |
| wbMemToReg | output | 1 | Writeback: select memory data for writeback |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the four class opcodes at their standard values. With those it can reach every class, the whole unused opcode space for R5, and every mix of bubble, flush and reset from one cycle to the next. Random opcode streams interleaved with bubble and flush show that each bundle keeps tracking its own instruction three stages deep. Directed runs cover back-to-back flushes, a flush together with a bubble, and a reset in the middle of a run.

// File: rtl/pipeCtrlPkg.sv
package pipeCtrlPkg;

  typedef struct packed {
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrc;
  } exCtl_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memCtl_t;

  typedef struct packed {
    logic regWrite;
    logic memToReg;
  } wbCtl_t;

  // entry held between decode and execute: every bundle
  typedef struct packed {
    exCtl_t  ex;
    memCtl_t mem;
    wbCtl_t  wb;
  } idExCtl_t;

  // entry held between execute and memory: execute bundle dropped
  typedef struct packed {
    memCtl_t mem;
    wbCtl_t  wb;
  } exMemCtl_t;

  // strobes from the sequencer to the register stages
  typedef struct packed {
    logic clearAll;
    logic zeroIdEx;
    logic zeroExMem;
  } stageStrobe_t;

  localparam logic [1:0] ALUOP_ADD = 2'b00;
  localparam logic [1:0] ALUOP_SUB = 2'b01;
  localparam logic [1:0] ALUOP_FUN = 2'b10;

endpackage

// File: rtl/ctrlDecoder.sv
module ctrlDecoder
  import pipeCtrlPkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_RFMT  = OP_W'(6'h00),
  parameter logic [OP_W-1:0] OP_LOAD  = OP_W'(6'h23),
  parameter logic [OP_W-1:0] OP_STORE = OP_W'(6'h2B),
  parameter logic [OP_W-1:0] OP_BEQ   = OP_W'(6'h04)
) (
  input  logic [OP_W-1:0] opcode,
  output idExCtl_t        ctlWord
);

  always_comb begin
    ctlWord = '0;
    unique case (opcode)
      OP_RFMT: begin
        ctlWord.ex.regDst   = 1'b1;
        ctlWord.ex.aluOp    = ALUOP_FUN;
        ctlWord.wb.regWrite = 1'b1;
      end
      OP_LOAD: begin
        ctlWord.ex.aluOp     = ALUOP_ADD;
        ctlWord.ex.aluSrc    = 1'b1;
        ctlWord.mem.memRead  = 1'b1;
        ctlWord.wb.regWrite  = 1'b1;
        ctlWord.wb.memToReg  = 1'b1;
      end
      OP_STORE: begin
        ctlWord.ex.aluOp     = ALUOP_ADD;
        ctlWord.ex.aluSrc    = 1'b1;
        ctlWord.mem.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctlWord.ex.aluOp   = ALUOP_SUB;
        ctlWord.mem.branch = 1'b1;
      end
      default: ctlWord = '0;
    endcase
  end

endmodule

// File: rtl/ctrlSequencer.sv
module ctrlSequencer
  import pipeCtrlPkg::*;
(
  input  logic         rst,
  input  logic         bubbleReq,
  input  logic         flushReq,
  output stageStrobe_t strobe
);

  always_comb begin
    strobe.clearAll  = rst;
    // a flush squashes decode and execute; a bubble only decode
    strobe.zeroIdEx  = bubbleReq | flushReq;
    strobe.zeroExMem = flushReq;
  end

endmodule

// File: rtl/ctrlStageRegs.sv
module ctrlStageRegs
  import pipeCtrlPkg::*;
(
  input  logic         clk,
  input  stageStrobe_t strobe,
  input  idExCtl_t     decWord,
  output idExCtl_t     idExQ,
  output exMemCtl_t    exMemQ,
  output wbCtl_t       memWbQ
);

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      idExQ  <= '0;
      exMemQ <= '0;
      memWbQ <= '0;
    end else begin
      idExQ      <= strobe.zeroIdEx ? '0 : decWord;
      exMemQ.mem <= strobe.zeroExMem ? '0 : idExQ.mem;
      exMemQ.wb  <= strobe.zeroExMem ? '0 : idExQ.wb;
      memWbQ     <= exMemQ.wb;
    end
  end

endmodule

// File: rtl/pipeCtrlDecoder.sv
module pipeCtrlDecoder
  import pipeCtrlPkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_RFMT  = OP_W'(6'h00),
  parameter logic [OP_W-1:0] OP_LOAD  = OP_W'(6'h23),
  parameter logic [OP_W-1:0] OP_STORE = OP_W'(6'h2B),
  parameter logic [OP_W-1:0] OP_BEQ   = OP_W'(6'h04)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            bubbleReq,
  input  logic            flushReq,
  output logic            exRegDst,
  output logic [1:0]      exAluOp,
  output logic            exAluSrc,
  output logic            memBranch,
  output logic            memRead,
  output logic            memWrite,
  output logic            wbRegWrite,
  output logic            wbMemToReg
);

  idExCtl_t     decWord;
  stageStrobe_t strobe;
  idExCtl_t     idExQ;
  exMemCtl_t    exMemQ;
  wbCtl_t       memWbQ;

  ctrlDecoder #(
    .OP_W(OP_W), .OP_RFMT(OP_RFMT), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ)
  ) dec_i (
    .opcode (opcode),
    .ctlWord(decWord)
  );

  ctrlSequencer seq_i (
    .rst      (rst),
    .bubbleReq(bubbleReq),
    .flushReq (flushReq),
    .strobe   (strobe)
  );

  ctrlStageRegs regs_i (
    .clk    (clk),
    .strobe (strobe),
    .decWord(decWord),
    .idExQ  (idExQ),
    .exMemQ (exMemQ),
    .memWbQ (memWbQ)
  );

  assign exRegDst   = idExQ.ex.regDst;
  assign exAluOp    = idExQ.ex.aluOp;
  assign exAluSrc   = idExQ.ex.aluSrc;
  assign memBranch  = exMemQ.mem.branch;
  assign memRead    = exMemQ.mem.memRead;
  assign memWrite   = exMemQ.mem.memWrite;
  assign wbRegWrite = memWbQ.regWrite;
  assign wbMemToReg = memWbQ.memToReg;

endmodule

// File: rtl/pipeCtrlDecoder_chk.sv
module pipeCtrlDecoder_chk
  import pipeCtrlPkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      bubbleReq,
  input logic      flushReq,
  input idExCtl_t  idExQ,
  input exMemCtl_t exMemQ,
  input wbCtl_t    memWbQ
);

  AST_BUBBLE_ZEROES_IDEX: assert property (@(posedge clk) disable iff (rst)
    bubbleReq |=> (idExQ == '0)); // R7

  AST_MEM_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !flushReq |=> (exMemQ.mem == $past(idExQ.mem) && exMemQ.wb == $past(idExQ.wb))); // R6

  AST_WB_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (memWbQ == $past(exMemQ.wb))); // R6

  AST_FLUSH_SQUASHES: assert property (@(posedge clk) disable iff (rst)
    flushReq |=> (idExQ == '0 && exMemQ == '0)); // R8

  AST_NO_READ_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(exMemQ.mem.memRead && exMemQ.mem.memWrite)); // R10

  AST_REGDST_ONLY_RFMT: assert property (@(posedge clk) disable iff (rst)
    idExQ.ex.regDst |-> (idExQ.ex.aluOp == ALUOP_FUN && !idExQ.ex.aluSrc)); // R1

endmodule

bind pipeCtrlDecoder pipeCtrlDecoder_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .bubbleReq(bubbleReq),
  .flushReq (flushReq),
  .idExQ    (idExQ),
  .exMemQ   (exMemQ),
  .memWbQ   (memWbQ)
);

// File: tb/pipeCtrlDecoder_tb_top.sv
`timescale 1ns/1ps
module pipeCtrlDecoder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic       bubbleReq = 1'b0;
  logic       flushReq = 1'b0;
  logic       exRegDst, exAluSrc, memBranch, memRead, memWrite, wbRegWrite, wbMemToReg;
  logic [1:0] exAluOp;

  int testsRun = 0;
  int testsFailed = 0;

  // expected state, bit order regDst aluOp1 aluOp0 aluSrc branch memRead memWrite regWrite memToReg
  logic [8:0] mIdEx = '0;
  logic [4:0] mExMem = '0;
  logic [1:0] mMemWb = '0;

  always #5 clk = ~clk;

  pipeCtrlDecoder dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .bubbleReq(bubbleReq), .flushReq(flushReq),
    .exRegDst(exRegDst), .exAluOp(exAluOp), .exAluSrc(exAluSrc),
    .memBranch(memBranch), .memRead(memRead), .memWrite(memWrite),
    .wbRegWrite(wbRegWrite), .wbMemToReg(wbMemToReg)
  );

  function automatic logic [8:0] expDecode(input logic [5:0] op);
    case (op)
      6'h00:   return 9'b1_10_0_000_10; // R1
      6'h23:   return 9'b0_00_1_010_11; // R2
      6'h2B:   return 9'b0_00_1_001_00; // R3
      6'h04:   return 9'b0_01_0_100_00; // R4
      default: return 9'b0;             // R5
    endcase
  endfunction

  function automatic logic [8:0] observed();
    return {exRegDst, exAluOp, exAluSrc, memBranch, memRead, memWrite, wbRegWrite, wbMemToReg};
  endfunction

  function automatic logic [8:0] expected();
    return {mIdEx[8:5], mExMem[4:2], mMemWb};
  endfunction

  task automatic check(input string tag);
    testsRun++;
    if (observed() !== expected()) begin
      testsFailed++;
      $display("FAIL %s: got %b expected %b", tag, observed(), expected());
    end
  endtask

  // drive one cycle at the falling edge, update the model, check after the next rising edge
  task automatic step(input logic [5:0] op, input logic bub, input logic fl, input logic r,
                      input string tag);
    opcode = op; bubbleReq = bub; flushReq = fl; rst = r;
    if (r) begin
      mIdEx = '0; mExMem = '0; mMemWb = '0;
    end else begin
      mMemWb = mExMem[1:0];
      mExMem = fl ? 5'b0 : mIdEx[4:0];
      mIdEx  = (bub || fl) ? 9'b0 : expDecode(op);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    @(negedge clk);
    step(6'h23, 1'b0, 1'b0, 1'b1, "R9 reset");
    step(6'h00, 1'b0, 1'b0, 1'b1, "R9 reset");

    // each class followed through all three stages
    step(6'h00, 0, 0, 0, "R1 rfmt");
    step(6'h3F, 0, 0, 0, "R1 rfmt mem");
    step(6'h3F, 0, 0, 0, "R1 rfmt wb");
    step(6'h23, 0, 0, 0, "R2 load");
    step(6'h01, 0, 0, 0, "R2 load mem");
    step(6'h01, 0, 0, 0, "R2 load wb");
    step(6'h2B, 0, 0, 0, "R3 store");
    step(6'h20, 0, 0, 0, "R3 store mem");
    step(6'h20, 0, 0, 0, "R3 store wb");
    step(6'h04, 0, 0, 0, "R4 beq");
    step(6'h05, 0, 0, 0, "R4 beq mem");
    step(6'h2A, 0, 0, 0, "R5 unknown");
    step(6'h22, 0, 0, 0, "R5 unknown");

    // back-to-back stream
    step(6'h23, 0, 0, 0, "R6 stream");
    step(6'h00, 0, 0, 0, "R6 stream");
    step(6'h2B, 0, 0, 0, "R6 stream");
    step(6'h04, 0, 0, 0, "R6 stream");

    // bubble behind a load
    step(6'h23, 0, 0, 0, "R7 setup");
    step(6'h00, 1, 0, 0, "R7 bubble");
    step(6'h00, 0, 0, 0, "R7 after bubble");
    step(6'h2B, 0, 0, 0, "R7 drain");

    // flush with full pipe, back-to-back flush, flush with bubble
    step(6'h23, 0, 0, 0, "R8 setup");
    step(6'h00, 0, 0, 0, "R8 setup");
    step(6'h2B, 0, 1, 0, "R8 flush");
    step(6'h23, 0, 1, 0, "R8 flush again");
    step(6'h00, 0, 0, 0, "R8 refill");
    step(6'h23, 1, 1, 0, "R8 flush with bubble");
    step(6'h00, 0, 0, 0, "R8 refill");

    // reset in the middle of a run
    step(6'h23, 0, 0, 0, "R9 setup");
    step(6'h23, 0, 0, 1, "R9 mid reset");
    step(6'h00, 0, 0, 0, "R9 after reset");

    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1:    op = 6'h00;
        2, 3:    op = 6'h23;
        4, 5:    op = 6'h2B;
        6, 7:    op = 6'h04;
        default: op = 6'($urandom_range(0, 63));
      endcase
      step(op, ($urandom_range(0, 9) == 0), ($urandom_range(0, 11) == 0),
           ($urandom_range(0, 99) == 0), "R6 random");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule